// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block holds the control state for the analog front end of a storage-interface PHY. Its seven 32-bit control words sit on a simple synchronous bus, and one read-only status word sits next to them. Each control word stores 16 bits.

On a write, the upper half of the data word is a per-bit enable for the lower half. A bit changes only when its enable is set, so a driver or a sequencer can flip one field with one write and no read-modify-write. The fields the PHY needs are decoded and driven straight out as ports: analog power, DLL enable, drive strength, DLL frequency band and output tap delay. Calibration-done and DLL-locked come back in as port bits and appear in the status word.

Reads are registered. Read data is valid on the cycle after the read strobe and is held until the next read.

Top module: `hwm_ctrl_bank`

## Requirements
- R1: On a write to a control word, stored bit x takes `bus_wdata[x]` only when `bus_wdata[x+16]` is 1. Every other stored bit keeps its value.
- R2: A read of a control word returns its 16 stored bits in `bus_rdata[15:0]`, with zeros in `bus_rdata[31:16]`. The data appears on the clock edge where `bus_rd` is sampled high.
- R3: Control words decode at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. Each address holds its own independent storage.
- R4: Writes to 0x20 or to any address that is not decoded change no stored bit. Reads of addresses that are not decoded return zero.
- R5: A read of 0x20 returns `cal_done_i` in bit 6 and `dll_lock_i` in bit 5. All other bits of that word are zero.
- R6: In the word at 0x18, bit 0 drives `pwr_en_o`, bit 1 drives `dll_en_o`, and bits 6:4 drive `drv_code_o`.
- R7: In the word at 0x00, bits 13:12 drive `freq_band_o`, bit 11 drives `otap_en_o`, and bits 10:7 drive `otap_val_o`.
- R8: A synchronous active-high `rst` clears every stored bit and the read data register to zero, so power and DLL are off.
- R9: When a read and a write target the same control word in the same cycle, the read returns the value from before the write.
- R10: While `bus_rd` is low, `bus_rdata` holds its last value, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bits 31:16 are the per-bit enables for bits 15:0 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration finished |
| dll_lock_i | input | 1 | DLL locked |
| pwr_en_o | output | 1 | Analog power enable |
| dll_en_o | output | 1 | DLL enable |
| drv_code_o | output | 3 | Drive-strength code |
| freq_band_o | output | 2 | DLL frequency band |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_val_o | output | 4 | Output tap delay value |

## Verification
A read and a masked write can land on the same control word in the same cycle. The bench provokes this by raising both strobes at 0x04 together, with a write that clears bits the read is fetching. It then checks that the read data shows the old contents. A second read, issued alone, must show the new contents. Zero-mask writes, partial-mask writes and writes to undecoded addresses are each judged by reading back the word and by watching the decoded field ports.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int ADDR_W  = 8;
    localparam int N_CTRL  = 7;
    localparam int STRIDE  = 4;

    localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h20;

    // word index of the two words the PHY fields live in
    localparam int IDX_PWR  = 6;
    localparam int IDX_DLYS = 0;

    // status bit positions
    localparam int ST_CAL  = 6;
    localparam int ST_LOCK = 5;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        half_t val;
    } slice_state_t;

    typedef struct packed {
        word_t rdata;
    } bank_state_t;
endpackage

// File: rtl/hwm_reg_slice.sv
module hwm_reg_slice
    import hwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wdata,
    output half_t q_o
);
    slice_state_t st_d, st_q;
    half_t        en_mask;

    always_comb begin
        en_mask = wdata[DATA_W-1:HALF_W];
        st_d    = st_q;
        if (wr_en) begin
            st_d.val = (st_q.val & ~en_mask) | (wdata[HALF_W-1:0] & en_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_o = st_q.val;

    // R1: bits without enable never move on a write
    p_unmasked_keep_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((q_o ^ $past(q_o)) & ~$past(wdata[DATA_W-1:HALF_W])) == '0));

    // R1: no write, no change
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q_o));
endmodule

// File: rtl/hwm_addr_decode.sv
module hwm_addr_decode
    import hwm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [N_CTRL-1:0] ctrl_sel,
    output logic              stat_sel
);
    for (genvar i = 0; i < N_CTRL; i++) begin : g_sel
        assign ctrl_sel[i] = (addr == ADDR_W'(i * STRIDE));
    end
    assign stat_sel = (addr == STAT_ADDR);

    // R3: at most one word selected
    always_comb begin
        p_decode_onehot_r3: assert ($onehot0({stat_sel, ctrl_sel}));
    end
endmodule

// File: rtl/hwm_read_mux.sv
module hwm_read_mux
    import hwm_pkg::*;
(
    input  half_t [N_CTRL-1:0] ctrl_q,
    input  logic  [N_CTRL-1:0] ctrl_sel,
    input  logic               stat_sel,
    input  logic               cal_done,
    input  logic               dll_lock,
    output word_t              data_o
);
    always_comb begin
        data_o = '0;
        for (int i = 0; i < N_CTRL; i++) begin
            if (ctrl_sel[i]) data_o[HALF_W-1:0] = ctrl_q[i];
        end
        if (stat_sel) begin
            data_o[ST_CAL]  = cal_done;
            data_o[ST_LOCK] = dll_lock;
        end
    end
endmodule

// File: rtl/hwm_ctrl_bank.sv
module hwm_ctrl_bank
    import hwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    input  logic        cal_done_i,
    input  logic        dll_lock_i,
    output logic        pwr_en_o,
    output logic        dll_en_o,
    output logic [2:0]  drv_code_o,
    output logic [1:0]  freq_band_o,
    output logic        otap_en_o,
    output logic [3:0]  otap_val_o
);
    logic [N_CTRL-1:0] ctrl_sel;
    logic              stat_sel;
    half_t [N_CTRL-1:0] ctrl_q;
    word_t             rd_word;
    bank_state_t       st_d, st_q;

    hwm_addr_decode u_dec (
        .addr     (bus_addr),
        .ctrl_sel (ctrl_sel),
        .stat_sel (stat_sel)
    );

    for (genvar i = 0; i < N_CTRL; i++) begin : g_word
        hwm_reg_slice u_slice (
            .clk   (clk),
            .rst   (rst),
            .wr_en (bus_wr & ctrl_sel[i]),
            .wdata (bus_wdata),
            .q_o   (ctrl_q[i])
        );
    end

    hwm_read_mux u_mux (
        .ctrl_q   (ctrl_q),
        .ctrl_sel (ctrl_sel),
        .stat_sel (stat_sel),
        .cal_done (cal_done_i),
        .dll_lock (dll_lock_i),
        .data_o   (rd_word)
    );

    // read data sampled from pre-write storage (R9)
    always_comb begin
        st_d = st_q;
        if (bus_rd) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bus_rdata   = st_q.rdata;
    assign pwr_en_o    = ctrl_q[IDX_PWR][0];
    assign dll_en_o    = ctrl_q[IDX_PWR][1];
    assign drv_code_o  = ctrl_q[IDX_PWR][6:4];
    assign freq_band_o = ctrl_q[IDX_DLYS][13:12];
    assign otap_en_o   = ctrl_q[IDX_DLYS][11];
    assign otap_val_o  = ctrl_q[IDX_DLYS][10:7];

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:16] == 16'h0);

    p_undef_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ctrl_sel == '0) |=> $stable(ctrl_q));

    p_pwr_field_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h18 && bus_wdata[16]) |=> (pwr_en_o == $past(bus_wdata[0])));

    p_band_field_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h00 && bus_wdata[29:28] == 2'b11)
            |=> (freq_band_o == $past(bus_wdata[13:12])));
endmodule

// File: tb/hwm_ctrl_bank_tb.sv
module hwm_ctrl_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cal_done_i = 1'b0;
    logic        dll_lock_i = 1'b0;
    logic        pwr_en_o, dll_en_o, otap_en_o;
    logic [2:0]  drv_code_o;
    logic [1:0]  freq_band_o;
    logic [3:0]  otap_val_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    hwm_ctrl_bank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cal_done_i(cal_done_i), .dll_lock_i(dll_lock_i),
        .pwr_en_o(pwr_en_o), .dll_en_o(dll_en_o), .drv_code_o(drv_code_o),
        .freq_band_o(freq_band_o), .otap_en_o(otap_en_o), .otap_val_o(otap_val_o)
    );

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h18, 32'h0001_0001, 32'h0},
        '{1'b1, 8'h18, 32'h0,         32'h0000_0001},
        '{1'b0, 8'h18, 32'h0002_FFFF, 32'h0},
        '{1'b1, 8'h18, 32'h0,         32'h0000_0003},
        '{1'b0, 8'h18, 32'h0000_0000, 32'h0},
        '{1'b1, 8'h18, 32'h0,         32'h0000_0003},
        '{1'b0, 8'h18, 32'h0071_0050, 32'h0},
        '{1'b1, 8'h18, 32'h0,         32'h0000_0052},
        '{1'b0, 8'h00, 32'hFFFF_3A80, 32'h0},
        '{1'b1, 8'h00, 32'h0,         32'h0000_3A80},
        '{1'b0, 8'h04, 32'hFFFF_1234, 32'h0},
        '{1'b1, 8'h04, 32'h0,         32'h0000_1234},
        '{1'b0, 8'h14, 32'h00FF_ABCD, 32'h0},
        '{1'b1, 8'h14, 32'h0,         32'h0000_00CD},
        '{1'b0, 8'h20, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 8'h1C, 32'hFFFF_FFFF, 32'h0},
        '{1'b1, 8'h1C, 32'h0,         32'h0},
        '{1'b1, 8'h24, 32'h0,         32'h0},
        '{1'b1, 8'h18, 32'h0,         32'h0000_0052},
        '{1'b1, 8'h08, 32'h0,         32'h0},
        '{1'b0, 8'h00, 32'h1000_0000, 32'h0},
        '{1'b1, 8'h00, 32'h0,         32'h0000_2A80}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_rdata, exp, req);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check({pwr_en_o, dll_en_o, drv_code_o, freq_band_o, otap_en_o, otap_val_o}, 32'h0, "R8 fields");
        check(bus_rdata, 32'h0, "R8 rdata");

        // R1 R2 R3 R4: table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) rd(VECS[i].addr, VECS[i].exp, "R1/R2/R3/R4 vector");
            else               wr(VECS[i].addr, VECS[i].data);
        end

        // R6 R7: decoded fields (0x18 = 0x52, 0x00 = 0x2A80)
        check({31'h0, pwr_en_o}, 32'h0, "R6 pwr");
        check({31'h0, dll_en_o}, 32'h1, "R6 dll");
        check({29'h0, drv_code_o}, 32'h5, "R6 drv");
        check({30'h0, freq_band_o}, 32'h2, "R7 band");
        check({31'h0, otap_en_o}, 32'h1, "R7 otap_en");
        check({28'h0, otap_val_o}, 32'h5, "R7 otap_val");

        // R5: status word
        cal_done_i = 1'b1; dll_lock_i = 1'b0;
        rd(8'h20, 32'h0000_0040, "R5 cal");
        dll_lock_i = 1'b1;
        rd(8'h20, 32'h0000_0060, "R5 both");
        cal_done_i = 1'b0;
        rd(8'h20, 32'h0000_0020, "R5 lock");

        // R9: read and write same word in the same cycle
        bus_addr = 8'h04; bus_wdata = 32'hFFFF_0000; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(bus_rdata, 32'h0000_1234, "R9 old value");
        rd(8'h04, 32'h0, "R9 new value");

        // R10: rdata holds across a write with no read
        rd(8'h00, 32'h0000_2A80, "R10 setup");
        wr(8'h00, 32'hFFFF_0000);
        check(bus_rdata, 32'h0000_2A80, "R10 hold");

        // R8: mid-run reset
        wr(8'h18, 32'h0003_0003);
        check({31'h0, pwr_en_o}, 32'h1, "R6 pwr on");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check({31'h0, pwr_en_o}, 32'h0, "R8 pwr cleared");
        check({31'h0, dll_en_o}, 32'h0, "R8 dll cleared");
        rd(8'h18, 32'h0, "R8 word cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule